// File: doc/BRIEF.md
# Sized Register File with Data and Address Banks

This block holds two banks of eight 32-bit registers: a data bank and an address bank. In the address bank, register 7 serves as the stack pointer. A single main write port carries a register class, an index, an operand size and a value. How a byte or word write lands in the register depends on the class. A data register keeps its untouched upper bits. An address register receives the value sign-extended to the full width.

A second write port is reserved for pointer updates, such as the step applied by post-increment and pre-decrement addressing. It writes a full 32-bit value into one address register.

Two independent read ports are provided. Each returns the full register value combinationally. Each also returns a lane view, in which the bits above the requested operand size are cleared, so that a consumer can take a byte or word operand directly.

Top module: `sized_regfile`

## Requirements
- R1: While `rst_ni` is low, all sixteen registers are cleared to zero. The reset is asynchronous.
- R2: A byte write (size 0) or word write (size 1) to a data register (class 0) replaces only bits [7:0] or [15:0]. All higher bits keep their previous value.
- R3: A byte or word write to an address register (class 1) stores the value sign-extended to 32 bits from bit 7 or bit 15. For example, byte 0x82 stores 0xFFFFFF82 and byte 0x7F stores 0x0000007F.
- R4: A long write (size 2; size 3 is handled as long) stores all 32 bits unchanged for either class.
- R5: Data and address registers with the same index are distinct. A write to one class leaves the other class untouched.
- R6: The read data is combinational and full width. During the cycle of a write, a read of the target shows the old value. The new value appears after the rising edge.
- R7: The lane output keeps bits [7:0] for size 0, bits [15:0] for size 1, and all bits for sizes 2 and 3. All other bits are zero.
- R8: The pointer port writes its full 32-bit value into the address register it selects. This happens even when the main port writes a different register in the same cycle.
- R9: When the main port writes an address register and the pointer port targets the same register in the same cycle, the main write is stored. A main write to the data register with that index does not block the pointer write.
- R10: With both write enables low, no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Main write enable |
| wr_cls_i | input | 1 | Main write class: 0 data, 1 address |
| wr_idx_i | input | 3 | Main write register index |
| wr_size_i | input | 2 | Main write size: 0 byte, 1 word, 2/3 long |
| wr_data_i | input | 32 | Main write value (low bits used for byte/word) |
| ptr_en_i | input | 1 | Pointer update enable |
| ptr_idx_i | input | 3 | Pointer update address register index |
| ptr_data_i | input | 32 | Pointer update value |
| rd0_cls_i | input | 1 | Read port 0 class |
| rd0_idx_i | input | 3 | Read port 0 index |
| rd0_size_i | input | 2 | Read port 0 lane size |
| rd0_data_o | output | 32 | Read port 0 full value |
| rd0_lane_o | output | 32 | Read port 0 size-masked value |
| rd1_cls_i | input | 1 | Read port 1 class |
| rd1_idx_i | input | 3 | Read port 1 index |
| rd1_size_i | input | 2 | Read port 1 lane size |
| rd1_data_o | output | 32 | Read port 1 full value |
| rd1_lane_o | output | 32 | Read port 1 size-masked value |

## Verification
The stimulus goes after the class split for partial writes, using operands on both sides of the sign bit.

- A design that sign-extended data registers would corrupt upper bits such as 0x1234 in 0x123456AB.
- A design that merged address writes would leave stale upper bits where 0xFFFFFF82 is expected.
- Conflicting pointer and main writes to one register are driven in the same cycle. A wrong priority would leave the pointer value in place of the sized write.
- Reads in the cycle of a write are checked for the old value, which exposes any write-through path.
- Reserved size 3 and the stack pointer index are both exercised.

// File: rtl/rf_pkg.sv
package rf_pkg;
  timeunit 1ns; timeprecision 1ps;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_WIDE = 2'd3   // treated as long
  } rf_size_e;

  typedef enum logic {
    CLS_DATA = 1'b0,
    CLS_ADDR = 1'b1
  } rf_class_e;
endpackage

// File: rtl/rf_wr_fmt.sv
module rf_wr_fmt
  import rf_pkg::*;
#(
  parameter int DW = 32,
  parameter int BW = 8,
  parameter int WW = 16
) (
  input  logic [DW-1:0] old_i,
  input  logic [DW-1:0] new_i,
  input  rf_size_e      size_i,
  input  rf_class_e     cls_i,
  output logic [DW-1:0] val_o
);
  timeunit 1ns; timeprecision 1ps;

  logic [DW-1:0] merge_b, merge_w, sext_b, sext_w;

  assign merge_b = {old_i[DW-1:BW], new_i[BW-1:0]};
  assign merge_w = {old_i[DW-1:WW], new_i[WW-1:0]};
  assign sext_b  = {{(DW-BW){new_i[BW-1]}}, new_i[BW-1:0]};
  assign sext_w  = {{(DW-WW){new_i[WW-1]}}, new_i[WW-1:0]};

  always_comb begin
    case (size_i)
      SZ_BYTE: val_o = (cls_i == CLS_ADDR) ? sext_b : merge_b;
      SZ_WORD: val_o = (cls_i == CLS_ADDR) ? sext_w : merge_w;
      default: val_o = new_i;
    endcase
  end
endmodule

// File: rtl/rf_bank.sv
module rf_bank
  import rf_pkg::*;
#(
  parameter int DW   = 32,
  parameter int NREG = 8,
  localparam int IW  = $clog2(NREG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  rf_class_e     wr_cls_i,
  input  logic [IW-1:0] wr_idx_i,
  input  logic [DW-1:0] wr_val_i,
  input  logic          ptr_en_i,
  input  logic [IW-1:0] ptr_idx_i,
  input  logic [DW-1:0] ptr_val_i,
  output logic [DW-1:0] dreg_o [NREG],
  output logic [DW-1:0] areg_o [NREG]
);
  timeunit 1ns; timeprecision 1ps;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic          d_we, a_we, p_we;
    logic [DW-1:0] d_q, a_q;

    assign d_we = wr_en_i && (wr_cls_i == CLS_DATA) && (wr_idx_i == IW'(i));
    assign a_we = wr_en_i && (wr_cls_i == CLS_ADDR) && (wr_idx_i == IW'(i));
    assign p_we = ptr_en_i && (ptr_idx_i == IW'(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   d_q <= '0;
      else if (d_we) d_q <= wr_val_i;
    end

    // main port has priority over pointer update
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   a_q <= '0;
      else if (a_we) a_q <= wr_val_i;
      else if (p_we) a_q <= ptr_val_i;
    end

    assign dreg_o[i] = d_q;
    assign areg_o[i] = a_q;
  end
endmodule

// File: rtl/rf_rd_port.sv
module rf_rd_port
  import rf_pkg::*;
#(
  parameter int DW   = 32,
  parameter int NREG = 8,
  parameter int BW   = 8,
  parameter int WW   = 16,
  localparam int IW  = $clog2(NREG)
) (
  input  rf_class_e     cls_i,
  input  logic [IW-1:0] idx_i,
  input  rf_size_e      size_i,
  input  logic [DW-1:0] dreg_i [NREG],
  input  logic [DW-1:0] areg_i [NREG],
  output logic [DW-1:0] data_o,
  output logic [DW-1:0] lane_o
);
  timeunit 1ns; timeprecision 1ps;

  assign data_o = (cls_i == CLS_ADDR) ? areg_i[idx_i] : dreg_i[idx_i];

  always_comb begin
    case (size_i)
      SZ_BYTE: lane_o = {{(DW-BW){1'b0}}, data_o[BW-1:0]};
      SZ_WORD: lane_o = {{(DW-WW){1'b0}}, data_o[WW-1:0]};
      default: lane_o = data_o;
    endcase
  end
endmodule

// File: rtl/sized_regfile.sv
module sized_regfile
  import rf_pkg::*;
#(
  parameter int DW   = 32,
  parameter int NREG = 8,
  parameter int BW   = 8,
  parameter int WW   = 16,
  localparam int IW  = $clog2(NREG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic          wr_cls_i,
  input  logic [IW-1:0] wr_idx_i,
  input  logic [1:0]    wr_size_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          ptr_en_i,
  input  logic [IW-1:0] ptr_idx_i,
  input  logic [DW-1:0] ptr_data_i,
  input  logic          rd0_cls_i,
  input  logic [IW-1:0] rd0_idx_i,
  input  logic [1:0]    rd0_size_i,
  output logic [DW-1:0] rd0_data_o,
  output logic [DW-1:0] rd0_lane_o,
  input  logic          rd1_cls_i,
  input  logic [IW-1:0] rd1_idx_i,
  input  logic [1:0]    rd1_size_i,
  output logic [DW-1:0] rd1_data_o,
  output logic [DW-1:0] rd1_lane_o
);
  timeunit 1ns; timeprecision 1ps;

  logic [DW-1:0] dreg_q [NREG];
  logic [DW-1:0] areg_q [NREG];
  logic [DW-1:0] wr_old, wr_val;

  // previous content of the target, needed for data-class merge
  assign wr_old = wr_cls_i ? areg_q[wr_idx_i] : dreg_q[wr_idx_i];

  rf_wr_fmt #(.DW(DW), .BW(BW), .WW(WW)) u_fmt (
    .old_i  (wr_old),
    .new_i  (wr_data_i),
    .size_i (rf_size_e'(wr_size_i)),
    .cls_i  (rf_class_e'(wr_cls_i)),
    .val_o  (wr_val)
  );

  rf_bank #(.DW(DW), .NREG(NREG)) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_cls_i  (rf_class_e'(wr_cls_i)),
    .wr_idx_i  (wr_idx_i),
    .wr_val_i  (wr_val),
    .ptr_en_i  (ptr_en_i),
    .ptr_idx_i (ptr_idx_i),
    .ptr_val_i (ptr_data_i),
    .dreg_o    (dreg_q),
    .areg_o    (areg_q)
  );

  rf_rd_port #(.DW(DW), .NREG(NREG), .BW(BW), .WW(WW)) u_rd0 (
    .cls_i  (rf_class_e'(rd0_cls_i)),
    .idx_i  (rd0_idx_i),
    .size_i (rf_size_e'(rd0_size_i)),
    .dreg_i (dreg_q),
    .areg_i (areg_q),
    .data_o (rd0_data_o),
    .lane_o (rd0_lane_o)
  );

  rf_rd_port #(.DW(DW), .NREG(NREG), .BW(BW), .WW(WW)) u_rd1 (
    .cls_i  (rf_class_e'(rd1_cls_i)),
    .idx_i  (rd1_idx_i),
    .size_i (rf_size_e'(rd1_size_i)),
    .dreg_i (dreg_q),
    .areg_i (areg_q),
    .data_o (rd1_data_o),
    .lane_o (rd1_lane_o)
  );
endmodule

// File: rtl/sized_regfile_chk.sv
module sized_regfile_chk #(
  parameter int DW   = 32,
  parameter int NREG = 8,
  localparam int IW  = $clog2(NREG)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_en_i,
  input logic          wr_cls_i,
  input logic [IW-1:0] wr_idx_i,
  input logic [1:0]    wr_size_i,
  input logic [DW-1:0] wr_data_i,
  input logic          ptr_en_i,
  input logic [IW-1:0] ptr_idx_i,
  input logic [DW-1:0] ptr_data_i,
  input logic [1:0]    rd0_size_i,
  input logic [DW-1:0] rd0_lane_o,
  input logic [DW-1:0] dreg_q [NREG],
  input logic [DW-1:0] areg_q [NREG]
);
  timeunit 1ns; timeprecision 1ps;

  logic          p_wv, p_cls, p_pv;
  logic [IW-1:0] p_idx, p_pidx;
  logic [1:0]    p_size;
  logic [DW-1:0] p_wdata, p_old, p_pdata, cur_old;
  logic [DW-1:0] p_d [NREG];
  logic [DW-1:0] p_a [NREG];
  logic          same_tgt;

  assign cur_old  = wr_cls_i ? areg_q[wr_idx_i] : dreg_q[wr_idx_i];
  assign same_tgt = p_wv && p_cls && p_pv && (p_idx == p_pidx);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p_wv <= 1'b0; p_cls <= 1'b0; p_pv <= 1'b0;
      p_idx <= '0; p_pidx <= '0; p_size <= '0;
      p_wdata <= '0; p_old <= '0; p_pdata <= '0;
    end else begin
      p_wv <= wr_en_i; p_cls <= wr_cls_i; p_pv <= ptr_en_i;
      p_idx <= wr_idx_i; p_pidx <= ptr_idx_i; p_size <= wr_size_i;
      p_wdata <= wr_data_i; p_old <= cur_old; p_pdata <= ptr_data_i;
    end
  end

  for (genvar k = 0; k < NREG; k++) begin : g_snap
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        p_d[k] <= '0; p_a[k] <= '0;
      end else begin
        p_d[k] <= dreg_q[k]; p_a[k] <= areg_q[k];
      end
    end

    assert_idle_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!p_wv && !p_pv) |-> (dreg_q[k] == p_d[k] && areg_q[k] == p_a[k]));

    assert_class_split_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (p_wv && !p_cls && !p_pv) |-> (areg_q[k] == p_a[k]));
  end

  assert_data_byte_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (p_wv && !p_cls && p_size == 2'd0) |->
      (dreg_q[p_idx][DW-1:8] == p_old[DW-1:8] && dreg_q[p_idx][7:0] == p_wdata[7:0]));

  assert_data_word_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (p_wv && !p_cls && p_size == 2'd1) |->
      (dreg_q[p_idx][DW-1:16] == p_old[DW-1:16] && dreg_q[p_idx][15:0] == p_wdata[15:0]));

  assert_addr_byte_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (p_wv && p_cls && p_size == 2'd0) |->
      (areg_q[p_idx] == {{(DW-8){p_wdata[7]}}, p_wdata[7:0]}));

  assert_addr_word_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (p_wv && p_cls && p_size == 2'd1) |->
      (areg_q[p_idx] == {{(DW-16){p_wdata[15]}}, p_wdata[15:0]}));

  assert_long_full_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (p_wv && p_size[1]) |->
      ((p_cls ? areg_q[p_idx] : dreg_q[p_idx]) == p_wdata));

  assert_ptr_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (p_pv && !same_tgt) |-> (areg_q[p_pidx] == p_pdata));

  assert_main_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    same_tgt |-> (areg_q[p_idx][7:0] == p_wdata[7:0]));

  assert_lane_byte_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd0_size_i == 2'd0) |-> (rd0_lane_o[DW-1:8] == '0));
endmodule

bind sized_regfile sized_regfile_chk #(.DW(DW), .NREG(NREG)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .wr_cls_i   (wr_cls_i),
  .wr_idx_i   (wr_idx_i),
  .wr_size_i  (wr_size_i),
  .wr_data_i  (wr_data_i),
  .ptr_en_i   (ptr_en_i),
  .ptr_idx_i  (ptr_idx_i),
  .ptr_data_i (ptr_data_i),
  .rd0_size_i (rd0_size_i),
  .rd0_lane_o (rd0_lane_o),
  .dreg_q     (dreg_q),
  .areg_q     (areg_q)
);

// File: tb/sized_regfile_tb.sv
module sized_regfile_tb;
  timeunit 1ns; timeprecision 1ps;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0, wr_cls_i = 1'b0;
  logic [2:0]  wr_idx_i = '0;
  logic [1:0]  wr_size_i = '0;
  logic [31:0] wr_data_i = '0;
  logic        ptr_en_i = 1'b0;
  logic [2:0]  ptr_idx_i = '0;
  logic [31:0] ptr_data_i = '0;
  logic        rd0_cls_i = 1'b0, rd1_cls_i = 1'b0;
  logic [2:0]  rd0_idx_i = '0, rd1_idx_i = '0;
  logic [1:0]  rd0_size_i = 2'd2, rd1_size_i = 2'd2;
  logic [31:0] rd0_data_o, rd0_lane_o, rd1_data_o, rd1_lane_o;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk_i = ~clk_i;  // 125 MHz

  sized_regfile u_dut (.*);

  typedef struct packed {
    logic        cls;
    logic [2:0]  idx;
    logic [1:0]  sz;
    logic [31:0] pre;
    logic [31:0] wd;
    logic [31:0] exp;
  } vec_t;

  // class 0 data / 1 address; size 0 byte, 1 word, 2-3 long
  localparam vec_t VEC [12] = '{
    '{1'b0, 3'd1, 2'd0, 32'h12345678, 32'h000000AB, 32'h123456AB},
    '{1'b0, 3'd2, 2'd1, 32'h12345678, 32'h0000BEEF, 32'h1234BEEF},
    '{1'b0, 3'd3, 2'd2, 32'h12345678, 32'hCAFEF00D, 32'hCAFEF00D},
    '{1'b1, 3'd1, 2'd0, 32'h12345678, 32'h00000082, 32'hFFFFFF82},
    '{1'b1, 3'd2, 2'd0, 32'hFFFFFFFF, 32'h0000007F, 32'h0000007F},
    '{1'b1, 3'd3, 2'd1, 32'h00000000, 32'h00008001, 32'hFFFF8001},
    '{1'b1, 3'd4, 2'd1, 32'hFFFF0000, 32'h12347FFF, 32'h00007FFF},
    '{1'b1, 3'd5, 2'd2, 32'h00000000, 32'h80000001, 32'h80000001},
    '{1'b0, 3'd7, 2'd0, 32'h00000000, 32'hFFFFFF82, 32'h00000082},
    '{1'b1, 3'd7, 2'd0, 32'h00000000, 32'h000000FF, 32'hFFFFFFFF},
    '{1'b0, 3'd0, 2'd3, 32'h00000000, 32'hDEADBEEF, 32'hDEADBEEF},
    '{1'b1, 3'd6, 2'd1, 32'h00000000, 32'h5555FFFE, 32'hFFFFFFFE}
  };

  function automatic logic [31:0] lane_of(logic [31:0] v, logic [1:0] sz);
    if (sz == 2'd0) return {24'h0, v[7:0]};
    if (sz == 2'd1) return {16'h0, v[15:0]};
    return v;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic cls, logic [2:0] idx, logic [1:0] sz, logic [31:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_cls_i = cls; wr_idx_i = idx; wr_size_i = sz; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(logic cls, logic [2:0] idx, output logic [31:0] v);
    rd0_cls_i = cls; rd0_idx_i = idx; rd0_size_i = 2'd2;
    #1 v = rd0_data_o;
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk_i);
    // R1: all registers zero out of reset
    for (int c = 0; c < 2; c++)
      for (int i = 0; i < 8; i++) begin
        rd(c[0], i[2:0], v);
        check("R1", v, 32'h0);
      end
    rst_ni = 1'b1;

    // R2 R3 R4 R7 vectors
    for (int k = 0; k < 12; k++) begin
      wr(VEC[k].cls, VEC[k].idx, 2'd2, VEC[k].pre);
      wr(VEC[k].cls, VEC[k].idx, VEC[k].sz, VEC[k].wd);
      rd(VEC[k].cls, VEC[k].idx, v);
      if (VEC[k].sz[1])     check("R4", v, VEC[k].exp);
      else if (VEC[k].cls)  check("R3", v, VEC[k].exp);
      else                  check("R2", v, VEC[k].exp);
      rd1_cls_i = VEC[k].cls; rd1_idx_i = VEC[k].idx; rd1_size_i = VEC[k].sz;
      #1 check("R7", rd1_lane_o, lane_of(VEC[k].exp, VEC[k].sz));
    end

    // R5: same index, separate classes
    wr(1'b0, 3'd3, 2'd2, 32'h11111111);
    wr(1'b1, 3'd3, 2'd2, 32'h22222222);
    rd(1'b0, 3'd3, v); check("R5", v, 32'h11111111);
    rd(1'b1, 3'd3, v); check("R5", v, 32'h22222222);

    // R6: old value during write cycle, new after edge
    wr(1'b0, 3'd4, 2'd2, 32'h0000000F);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_cls_i = 1'b0; wr_idx_i = 3'd4; wr_size_i = 2'd2; wr_data_i = 32'hAAAA5555;
    rd0_cls_i = 1'b0; rd0_idx_i = 3'd4; rd0_size_i = 2'd2;
    #1 check("R6", rd0_data_o, 32'h0000000F);
    @(negedge clk_i);
    wr_en_i = 1'b0;
    #1 check("R6", rd0_data_o, 32'hAAAA5555);

    // R7: word lane on an address register
    rd1_cls_i = 1'b1; rd1_idx_i = 3'd3; rd1_size_i = 2'd1;
    #1 check("R7", rd1_lane_o, 32'h00002222);

    // R8: pointer and main write to different address registers
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_cls_i = 1'b1; wr_idx_i = 3'd5; wr_size_i = 2'd0; wr_data_i = 32'h00000090;
    ptr_en_i = 1'b1; ptr_idx_i = 3'd2; ptr_data_i = 32'h00FC1D2A;
    @(negedge clk_i);
    wr_en_i = 1'b0; ptr_en_i = 1'b0;
    rd(1'b1, 3'd2, v); check("R8", v, 32'h00FC1D2A);
    rd(1'b1, 3'd5, v); check("R8", v, 32'hFFFFFF90);

    // R8: stack pointer step
    @(negedge clk_i);
    ptr_en_i = 1'b1; ptr_idx_i = 3'd7; ptr_data_i = 32'h00001002;
    @(negedge clk_i);
    ptr_en_i = 1'b0;
    rd(1'b1, 3'd7, v); check("R8", v, 32'h00001002);

    // R9: same address register, main wins
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_cls_i = 1'b1; wr_idx_i = 3'd6; wr_size_i = 2'd1; wr_data_i = 32'h00000004;
    ptr_en_i = 1'b1; ptr_idx_i = 3'd6; ptr_data_i = 32'h00001000;
    @(negedge clk_i);
    wr_en_i = 1'b0; ptr_en_i = 1'b0;
    rd(1'b1, 3'd6, v); check("R9", v, 32'h00000004);

    // R9: data-class main write does not block pointer to same index
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_cls_i = 1'b0; wr_idx_i = 3'd6; wr_size_i = 2'd2; wr_data_i = 32'h66666666;
    ptr_en_i = 1'b1; ptr_idx_i = 3'd6; ptr_data_i = 32'h00002000;
    @(negedge clk_i);
    wr_en_i = 1'b0; ptr_en_i = 1'b0;
    rd(1'b1, 3'd6, v); check("R9", v, 32'h00002000);
    rd(1'b0, 3'd6, v); check("R9", v, 32'h66666666);

    // R10: enables low, inputs toggling
    @(negedge clk_i);
    wr_cls_i = 1'b0; wr_idx_i = 3'd1; wr_size_i = 2'd2; wr_data_i = 32'h0BADF00D;
    ptr_idx_i = 3'd1; ptr_data_i = 32'h0BADF00D;
    repeat (2) @(negedge clk_i);
    rd(1'b0, 3'd1, v); check("R10", v, 32'h123456AB);
    rd(1'b1, 3'd1, v); check("R10", v, 32'hFFFFFF82);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule